// File: doc/BRIEF.md
# Address-filtering serial receiver

This block receives asynchronous serial frames with eight or nine data bits and a stop bit. It oversamples the line with an external tick at sixteen times the bit rate and settles each bit by a majority vote near the middle of the bit period. It reports a missing stop bit through a sticky framing-error flag.

For multi-drop buses, the receiver can compare each incoming byte in hardware against a slave address and a per-bit mask. With filtering enabled, the receive flag rises only for frames addressed to this node, so software does not have to inspect every address on the bus. A single status output carries either the framing-error flag or the upper mode bit, depending on a select input.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, `rx_data`, `rx_bit9`, `ri` and the framing-error flag are 0.
- R2: In mode 2'b01 (8-bit), a frame is a low start bit, eight data bits sent LSB first, and a stop bit. With `sm2`=0, every completed frame loads `rx_data` and sets `ri`. In this mode `rx_bit9` takes the sampled stop-bit value.
- R3: In modes 2'b10 and 2'b11 (9-bit), a ninth bit follows the eight data bits. Every completed frame latches that bit into `rx_bit9` and loads `rx_data`, whether or not the frame passes the address filter.
- R4: Each bit is the majority of samples 7, 8 and 9 of its 16 ticks. A start bit whose majority is high is rejected, and nothing is updated.
- R5: A stop bit sampled as 0 sets the framing-error flag. Only `fe_clr` clears it. Later good frames leave it set.
- R6: `status7` equals the framing-error flag when `smod0`=1, and equals `mode[1]` when `smod0`=0.
- R7: In 9-bit mode with `sm2`=1, `ri` is set only when the ninth bit is 1 and the byte matches the given or the broadcast address.
- R8: In 8-bit mode with `sm2`=1, `ri` is set only when the stop bit is 1 and the byte matches the given or the broadcast address.
- R9: The byte matches the given address when every bit with `addr_mask`=1 equals the corresponding `slave_addr` bit. Bits with mask 0 are ignored.
- R10: The byte matches the broadcast address when it is 1 in every position where `slave_addr | addr_mask` is 1.
- R11: With `slave_addr` and `addr_mask` both 0, every byte matches.
- R12: In mode 2'b00 (shift mode, not handled here), the receiver ignores the line and `sm2`. No output changes.
- R13: `ri` stays set until `ri_clr` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial input line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| mode | input | 2 | 00 shift (idle), 01 8-bit, 10/11 9-bit |
| sm2 | input | 1 | Address filter enable |
| smod0 | input | 1 | Selects what `status7` shows |
| slave_addr | input | 8 | Node address |
| addr_mask | input | 8 | Per-bit address mask |
| ri_clr | input | 1 | Clears the receive flag |
| fe_clr | input | 1 | Clears the framing-error flag |
| rx_data | output | 8 | Last received byte |
| rx_bit9 | output | 1 | Ninth bit (9-bit mode) or stop bit (8-bit mode) |
| ri | output | 1 | Receive flag |
| status7 | output | 1 | Framing-error flag or `mode[1]` |

## Verification
The assertions check three things on every cycle: that the receive and framing-error flags hold until their clear inputs, that the receiver stays idle in shift mode, and that any rise of `ri` under filtering comes with a ninth or stop bit of 1. Only the bench scenarios can show the rest: the address-match decisions for given, broadcast and all-zero settings, majority rejection of a short start glitch, the stop-bit framing error, and the selection on `status7`. The bench compares each of these against a behavioural model on every clock between frames.

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd,
  input  logic          baud_tick,
  input  logic [1:0]    mode,
  input  logic          sm2,
  input  logic          smod0,
  input  logic [DW-1:0] slave_addr,
  input  logic [DW-1:0] addr_mask,
  input  logic          ri_clr,
  input  logic          fe_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          ri,
  output logic          status7
);
  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(DW);
  localparam int MID = OSR / 2;

  typedef enum logic [2:0] {IDLE, START, DATA, NINTH, STOP, WAITHI} st_t;
  st_t st;

  logic [1:0]    sync;
  logic          rxs;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [1:0]    smp;
  logic [DW-1:0] sr;
  logic          b9, fe;
  logic          nine, vote, mid, last;
  logic          given_hit, bcast_hit, tag_bit, accept;

  assign rxs  = sync[1];
  assign nine = mode[1];
  assign mid  = baud_tick && cnt == CW'(MID + 1);
  assign last = baud_tick && cnt == CW'(OSR - 1);
  assign vote = (smp[1] & smp[0]) | (smp[1] & rxs) | (smp[0] & rxs);

  // R9: given-address compare, R10: broadcast compare
  assign given_hit = &(~(sr ^ slave_addr) | ~addr_mask);
  assign bcast_hit = &(sr | ~(slave_addr | addr_mask));
  assign tag_bit   = nine ? b9 : vote;
  assign accept    = !sm2 || (tag_bit && (given_hit || bcast_hit));

  assign status7 = smod0 ? fe : mode[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; bitn <= '0; smp <= '0; sr <= '0; b9 <= 1'b0;
    end else begin
      if (baud_tick) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(MID - 1) || cnt == CW'(MID)) smp <= {smp[0], rxs};
      end
      case (st)
        IDLE:
          if (baud_tick && !rxs && mode != 2'b00) begin
            st <= START; cnt <= '0;
          end
        START:
          if (mid && vote) st <= IDLE;
          else if (last) begin
            st <= DATA; bitn <= '0;
          end
        DATA: begin
          if (mid) sr <= {vote, sr[DW-1:1]};
          if (last) begin
            if (bitn == BW'(DW - 1)) st <= nine ? NINTH : STOP;
            else                     bitn <= bitn + 1'b1;
          end
        end
        NINTH: begin
          if (mid) b9 <= vote;
          if (last) st <= STOP;
        end
        STOP:
          if (mid) st <= WAITHI;
        WAITHI:
          if (rxs) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rx_bit9 <= 1'b0; ri <= 1'b0; fe <= 1'b0;
    end else begin
      if (ri_clr) ri <= 1'b0;
      if (fe_clr) fe <= 1'b0;
      if (st == STOP && mid) begin
        rx_data <= sr;
        rx_bit9 <= tag_bit;
        if (!vote)  fe <= 1'b1;
        if (accept) ri <= 1'b1;
      end
    end
  end

  a_r13_ri_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ri && !ri_clr) |=> ri);
  a_r5_fe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fe && !fe_clr) |=> fe);
  a_r12_shift_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && st == IDLE) |=> st == IDLE);
  a_r7_ninth_set: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ri) && sm2 && mode[1]) |-> rx_bit9);
  a_r8_stop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ri) && sm2 && mode == 2'b01) |-> (rx_bit9 && !$rose(status7 && smod0)));
endmodule

// File: tb/uart_addr_rx_tb.sv
module uart_addr_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic baud_tick;
  logic [1:0] mode = 2'b01;
  logic sm2 = 1'b0, smod0 = 1'b0;
  logic [7:0] slave_addr = 8'h00, addr_mask = 8'h00;
  logic ri_clr = 1'b0, fe_clr = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit9, ri, status7;

  logic [1:0] tcnt = 2'd0;
  int vectors = 0, miscompares = 0;
  string req = "R1";
  logic [7:0] e_data = 8'h00;
  logic e_b9 = 1'b0, e_ri = 1'b0, e_fe = 1'b0;

  always #4 clk = ~clk;
  always @(negedge clk) tcnt <= tcnt + 2'd1;
  assign baud_tick = (tcnt == 2'd0);

  uart_addr_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick), .mode(mode),
    .sm2(sm2), .smod0(smod0), .slave_addr(slave_addr), .addr_mask(addr_mask),
    .ri_clr(ri_clr), .fe_clr(fe_clr), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .ri(ri), .status7(status7));

  task automatic cmp();
    logic e_st;
    e_st = smod0 ? e_fe : mode[1];
    vectors++;
    if (rx_data !== e_data) begin
      miscompares++;
      $display("FAIL %s rx_data actual %h expected %h", req, rx_data, e_data);
    end
    if (rx_bit9 !== e_b9) begin
      miscompares++;
      $display("FAIL %s rx_bit9 actual %b expected %b", req, rx_bit9, e_b9);
    end
    if (ri !== e_ri) begin
      miscompares++;
      $display("FAIL %s ri actual %b expected %b", req, ri, e_ri);
    end
    if (status7 !== e_st) begin
      miscompares++;
      $display("FAIL %s/R6 status7 actual %b expected %b", req, status7, e_st);
    end
  endtask

  task automatic gap(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp();
    end
  endtask

  task automatic hold(logic v, int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic addr_ok(logic [7:0] d);
    logic g, b;
    g = 1'b1; b = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (addr_mask[i] && d[i] != slave_addr[i]) g = 1'b0;
      if ((slave_addr[i] || addr_mask[i]) && !d[i]) b = 1'b0;
    end
    return g || b;
  endfunction

  task automatic frame(logic [7:0] d, logic n9, logic stop);
    logic tag;
    @(negedge clk);
    hold(1'b0, 64);
    for (int i = 0; i < 8; i++) hold(d[i], 64);
    if (mode[1]) hold(n9, 64);
    hold(stop, 64);
    rxd = 1'b1;
    if (mode != 2'b00) begin
      tag = mode[1] ? n9 : stop;
      e_data = d;
      e_b9 = tag;
      if (!stop) e_fe = 1'b1;
      if (!sm2 || (tag && addr_ok(d))) e_ri = 1'b1;
    end
    gap(30);
  endtask

  task automatic clr_ri();
    ri_clr = 1'b1; e_ri = 1'b0;
    @(negedge clk);
    ri_clr = 1'b0;
    gap(4);
  endtask

  task automatic clr_fe();
    fe_clr = 1'b1; e_fe = 1'b0;
    @(negedge clk);
    fe_clr = 1'b0;
    gap(4);
  endtask

  initial begin
    #(200000 * 8);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    req = "R1"; gap(10);

    req = "R2"; frame(8'hA5, 1'b0, 1'b1);
    req = "R13"; gap(40); clr_ri();

    req = "R4";
    @(negedge clk); hold(1'b0, 12); hold(1'b1, 52); gap(30);

    req = "R5"; frame(8'h3C, 1'b0, 1'b0);
    req = "R6"; smod0 = 1'b1; gap(5);
    req = "R5"; clr_ri(); frame(8'h81, 1'b0, 1'b1); clr_ri(); clr_fe();
    req = "R6"; smod0 = 1'b0; gap(5);

    mode = 2'b10; sm2 = 1'b1; slave_addr = 8'hC0; addr_mask = 8'hFD;
    req = "R9";  frame(8'hC2, 1'b1, 1'b1); clr_ri();
    req = "R3";  frame(8'hC1, 1'b1, 1'b1);
    req = "R7";  frame(8'hC0, 1'b0, 1'b1);
    req = "R10"; frame(8'hFF, 1'b1, 1'b1); clr_ri();
    mode = 2'b11;
    req = "R9";  slave_addr = 8'hE0; addr_mask = 8'hFA; frame(8'hE4, 1'b1, 1'b1); clr_ri();

    mode = 2'b01; slave_addr = 8'hC0; addr_mask = 8'hFD;
    req = "R8"; frame(8'hC0, 1'b0, 1'b1); clr_ri();
    frame(8'hC0, 1'b0, 1'b0); clr_fe();
    frame(8'h12, 1'b0, 1'b1);

    mode = 2'b11; slave_addr = 8'h00; addr_mask = 8'h00;
    req = "R11"; frame(8'h5A, 1'b1, 1'b1); clr_ri();
    frame(8'h5A, 1'b0, 1'b1);

    mode = 2'b00;
    req = "R12"; frame(8'h77, 1'b1, 1'b1);
    sm2 = 1'b0; frame(8'h66, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule